// File: doc/BRIEF.md
# Pipelined Byte-Writable Burst SRAM

This block is a synchronous static memory with 18-bit words, split into two 9-bit byte lanes with separate active-low write enables. Address, data, lane enables, select and the burst controls are all taken at the rising clock edge, and a write lands in the array at that same edge. Read data goes through an output register, so a read sampled at one edge is presented after the next edge. An output-drive enable is gated by an output-enable input that acts without the clock.

A new access can be opened by one of two start strobes. The processor-side strobe always performs a read and ignores the lane enables. The controller-side strobe reads or writes according to the lane enables. After a start, cycles with both strobes high either step a 2-bit burst counter (advance low) or hold it (advance high). The counter walks the four words of the aligned group in interleaved order and wraps back to the starting word. A processor-side write therefore takes two cycles: a start that opens the burst, then a held cycle carrying the data and lane enables. Depth is a parameter. Address bits above the depth are ignored.

Top module: `burst_pipe_sram`

## Requirements
- R1: `lo_we_n` low writes bits 8:0 and `hi_we_n` low writes bits 17:9 of the addressed word. A lane whose enable is high keeps its old contents.
- R2: A read sampled at rising edge N drives its word on `dout` with `dout_en` high from edge N+1 until edge N+2, provided `oe_n` is low and no write is sampled at edge N+1.
- R3: A start with `proc_start_n` low and `sel_n` low is a read of `addr`, whatever the lane enables are. The memory is not changed.
- R4: A start with `proc_start_n` high, `ctrl_start_n` low and `sel_n` low is a write if either lane enable is low, and a read otherwise. Either way it uses `addr`.
- R5: A processor start at address A, followed by a cycle with both strobes high, `adv_n` high and a lane enable low, writes `din` to A.
- R6: In a burst cycle (both strobes high, burst open) with `adv_n` low, the counter steps before the access. Address bits 1:0 become the start address bits 1:0 XOR the beat count, the upper bits are held, and after four steps the address is back at the start word.
- R7: In a burst cycle with `adv_n` high, the access repeats the current burst address. It reads or writes according to the lane enables.
- R8: `dout_en` is low while `oe_n` is high. It is also low in the cycle after a sampled write, and in the cycle after a cycle with no read.
- R9: A start strobe with `sel_n` high performs no access and closes the burst. Burst cycles that follow it perform no access until the next start.
- R10: Address bits at and above log2(DEPTH) are ignored: an access to 16'hAB07 reaches the same word as one to 16'h0007 when DEPTH is 256.
- R11: While `rst_n` is low, and after it is released, `dout_en` is low and no burst is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | 16 | Word address. Upper bits beyond the depth are ignored |
| din | input | 18 | Write data |
| lo_we_n | input | 1 | Active-low write enable, bits 8:0 |
| hi_we_n | input | 1 | Active-low write enable, bits 17:9 |
| sel_n | input | 1 | Active-low select, looked at only with a start strobe |
| proc_start_n | input | 1 | Processor-side start strobe, active low, read only |
| ctrl_start_n | input | 1 | Controller-side start strobe, active low |
| adv_n | input | 1 | Active-low burst advance |
| oe_n | input | 1 | Active-low output enable, not clocked |
| dout | output | 18 | Registered read data |
| dout_en | output | 1 | High when `dout` should drive the shared data bus |

## Verification
The hardest situation to reach is a burst beat that lands on the output register at the same edge a write is sampled. That write might be the second half of a processor-side write, or a controller write that follows a read. When this happens, the pending read data must be suppressed rather than driven. The stimulus places such writes directly behind reads, including the processor two-cycle write whose first half is a read. The scoreboard retracts the drive expectation of the read in flight. Bursts are run from a start word in the middle of a group so that the interleaved order and the wrap are both visible. Suspend beats and a closed burst after a deselect are included.

// File: rtl/pbr_pkg.sv
`timescale 1ns/1ps
package pbr_pkg;
  localparam int LANES = 2;

  typedef enum logic [2:0] {
    CY_IDLE,
    CY_DESEL,
    CY_START,
    CY_STEP,
    CY_HOLD
  } cyc_e;

  // low two address bits of a burst beat
  function automatic logic [1:0] beat_low(input logic [1:0] start_lo,
                                          input logic [1:0] beat,
                                          input bit linear);
    if (linear) return start_lo + beat;
    return start_lo ^ beat;
  endfunction

  // any lane enable asserted (active low vector)
  function automatic logic lane_hit(input logic [LANES-1:0] we_n);
    return ~&we_n;
  endfunction
endpackage

// File: rtl/pbr_ctrl.sv
`timescale 1ns/1ps
module pbr_ctrl
  import pbr_pkg::*;
#(
  parameter int AW     = 8,
  parameter bit LINEAR = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proc_start_n,
  input  logic             ctrl_start_n,
  input  logic             adv_n,
  input  logic             sel_n,
  input  logic [LANES-1:0] we_n,
  input  logic [AW-1:0]    addr,
  output logic             op_rd,
  output logic             op_wr,
  output logic [AW-1:0]    op_addr,
  output logic [LANES-1:0] op_lane,
  output logic             burst_act,
  output cyc_e             cyc_kind
);
  logic          act_q;
  logic [AW-1:0] base_q;
  logic [1:0]    cnt_q;
  logic [1:0]    cnt_nx;
  logic [1:0]    step_lo;

  assign cnt_nx = adv_n ? cnt_q : cnt_q + 2'd1;

  generate
    if (LINEAR) begin : g_lin
      assign step_lo = beat_low(base_q[1:0], cnt_nx, 1'b1);
    end else begin : g_ilv
      assign step_lo = beat_low(base_q[1:0], cnt_nx, 1'b0);
    end
  endgenerate

  always_comb begin
    cyc_kind = CY_IDLE;
    op_rd    = 1'b0;
    op_wr    = 1'b0;
    op_addr  = addr;
    if (!proc_start_n || !ctrl_start_n) begin
      if (sel_n) begin
        cyc_kind = CY_DESEL;
      end else begin
        cyc_kind = CY_START;
        if (!proc_start_n)       op_rd = 1'b1;
        else if (lane_hit(we_n)) op_wr = 1'b1;
        else                     op_rd = 1'b1;
      end
    end else if (act_q) begin
      cyc_kind = adv_n ? CY_HOLD : CY_STEP;
      op_addr  = {base_q[AW-1:2], step_lo};
      op_wr    = lane_hit(we_n);
      op_rd    = ~lane_hit(we_n);
    end
  end

  assign op_lane   = op_wr ? ~we_n : '0;
  assign burst_act = act_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
    end else begin
      case (cyc_kind)
        CY_DESEL: act_q <= 1'b0;
        CY_START: begin
          act_q  <= 1'b1;
          base_q <= addr;
          cnt_q  <= '0;
        end
        CY_STEP, CY_HOLD: cnt_q <= cnt_nx;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/pbr_array.sv
`timescale 1ns/1ps
module pbr_array #(
  parameter int DEPTH  = 256,
  parameter int AW     = 8,
  parameter int LANE_W = 9,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic [LANES-1:0]        wr_lane,
  input  logic [AW-1:0]           wr_addr,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    rd_en,
  input  logic [AW-1:0]           rd_addr,
  output logic [LANES*LANE_W-1:0] rd_data
);
  generate
    for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] bank [DEPTH];
      logic [LANE_W-1:0] q;
      always_ff @(posedge clk) begin
        if (wr_lane[g]) bank[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        if (rd_en)      q <= bank[rd_addr];
      end
      assign rd_data[g*LANE_W +: LANE_W] = q;
    end
  endgenerate
endmodule

// File: rtl/pbr_outpipe.sv
`timescale 1ns/1ps
module pbr_outpipe #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_rd,
  input  logic          op_wr,
  input  logic [AW-1:0] op_addr,
  input  logic          oe_n,
  output logic          fetch_en,
  output logic [AW-1:0] fetch_addr,
  output logic          dout_en
);
  logic vld_q;
  logic wr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_en   <= 1'b0;
      fetch_addr <= '0;
      vld_q      <= 1'b0;
      wr_q       <= 1'b0;
    end else begin
      fetch_en   <= op_rd;
      fetch_addr <= op_addr;
      vld_q      <= fetch_en;
      wr_q       <= op_wr;
    end
  end

  assign dout_en = vld_q & ~wr_q & ~oe_n;
endmodule

// File: rtl/burst_pipe_sram.sv
`timescale 1ns/1ps
module burst_pipe_sram
  import pbr_pkg::*;
#(
  parameter int ADDR_W       = 16,
  parameter int DATA_W       = 18,
  parameter int DEPTH        = 256,
  parameter bit LINEAR_ORDER = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  input  logic              lo_we_n,
  input  logic              hi_we_n,
  input  logic              sel_n,
  input  logic              proc_start_n,
  input  logic              ctrl_start_n,
  input  logic              adv_n,
  input  logic              oe_n,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en
);
  localparam int AW     = $clog2(DEPTH);
  localparam int LANE_W = DATA_W / LANES;

  logic             op_rd;
  logic             op_wr;
  logic [AW-1:0]    op_addr;
  logic [LANES-1:0] op_lane;
  logic             burst_act;
  cyc_e             cyc_kind;
  logic             fetch_en;
  logic [AW-1:0]    fetch_addr;
  logic             unused_hi;

  assign unused_hi = ^addr[ADDR_W-1:AW];

  pbr_ctrl #(.AW(AW), .LINEAR(LINEAR_ORDER)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .proc_start_n (proc_start_n),
    .ctrl_start_n (ctrl_start_n),
    .adv_n        (adv_n),
    .sel_n        (sel_n),
    .we_n         ({hi_we_n, lo_we_n}),
    .addr         (addr[AW-1:0]),
    .op_rd        (op_rd),
    .op_wr        (op_wr),
    .op_addr      (op_addr),
    .op_lane      (op_lane),
    .burst_act    (burst_act),
    .cyc_kind     (cyc_kind)
  );

  pbr_array #(.DEPTH(DEPTH), .AW(AW), .LANE_W(LANE_W), .LANES(LANES)) u_array (
    .clk     (clk),
    .wr_lane (op_lane),
    .wr_addr (op_addr),
    .wr_data (din),
    .rd_en   (fetch_en),
    .rd_addr (fetch_addr),
    .rd_data (dout)
  );

  pbr_outpipe #(.AW(AW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_rd      (op_rd),
    .op_wr      (op_wr),
    .op_addr    (op_addr),
    .oe_n       (oe_n),
    .fetch_en   (fetch_en),
    .fetch_addr (fetch_addr),
    .dout_en    (dout_en)
  );
endmodule

// File: rtl/pbr_checker.sv
`timescale 1ns/1ps
module pbr_checker #(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          proc_start_n,
  input logic          ctrl_start_n,
  input logic          adv_n,
  input logic          sel_n,
  input logic          oe_n,
  input logic          dout_en,
  input logic          op_rd,
  input logic          op_wr,
  input logic [AW-1:0] op_addr,
  input logic          burst_act
);
  // R2: a read followed by a non-write cycle is driven unless oe_n blocks it
  p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(op_rd && rst_n) && !op_wr) |=> (dout_en || oe_n));

  // R8: nothing is driven in the cycle after a sampled write
  p_hiz_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr |=> !dout_en);

  // R3: the processor strobe never produces a write
  p_proc_no_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_start_n |-> !op_wr);

  // R9: a start strobe while deselected performs no access
  p_desel_no_access_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((!proc_start_n || !ctrl_start_n) && sel_n) |-> !(op_rd || op_wr));

  // R7: a held burst cycle repeats the previous access address
  p_hold_same_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_act && proc_start_n && ctrl_start_n && adv_n) |-> (op_addr == $past(op_addr)));

  // R6: an advancing beat keeps the group and moves inside it
  p_step_in_group_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_act && proc_start_n && ctrl_start_n && !adv_n) |->
      ((op_addr[AW-1:2] == $past(op_addr[AW-1:2])) && (op_addr[1:0] != $past(op_addr[1:0]))));
endmodule

bind burst_pipe_sram pbr_checker #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .proc_start_n (proc_start_n),
  .ctrl_start_n (ctrl_start_n),
  .adv_n        (adv_n),
  .sel_n        (sel_n),
  .oe_n         (oe_n),
  .dout_en      (dout_en),
  .op_rd        (op_rd),
  .op_wr        (op_wr),
  .op_addr      (op_addr),
  .burst_act    (burst_act)
);

// File: tb/test_burst_pipe_sram.sv
`timescale 1ns/1ps
module test_burst_pipe_sram;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [17:0] din = '0;
  logic        lo_we_n = 1'b1, hi_we_n = 1'b1, sel_n = 1'b1;
  logic        proc_start_n = 1'b1, ctrl_start_n = 1'b1, adv_n = 1'b1, oe_n = 1'b0;
  logic [17:0] dout;
  logic        dout_en;

  int checks = 0;
  int fails  = 0;
  int edges  = 0;
  bit done   = 0;

  typedef struct {
    int          due;
    bit          drive;
    logic [17:0] data;
    string       req;
  } exp_t;

  exp_t        sb[$];
  logic [17:0] shadow [256];

  always #4 clk = ~clk;
  always @(posedge clk) edges <= edges + 1;

  burst_pipe_sram i_burst_pipe_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .din(din),
    .lo_we_n(lo_we_n), .hi_we_n(hi_we_n), .sel_n(sel_n),
    .proc_start_n(proc_start_n), .ctrl_start_n(ctrl_start_n),
    .adv_n(adv_n), .oe_n(oe_n), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [17:0] pat(input int i);
    return 18'((i * 18'h0137) ^ 18'h2A5A5);
  endfunction

  // interleaved beat address, written bit by bit
  function automatic int beat_addr(input int base, input int beat);
    int b1, b0;
    b1 = ((base >> 1) & 1) ^ ((beat >> 1) & 1);
    b0 = (base & 1) ^ (beat & 1);
    return (base & 16'hFFFC) | (b1 << 1) | b0;
  endfunction

  // kind: 0 no access, 1 read, 2 write
  task automatic cyc(input logic ps, input logic cs, input logic adv,
                     input logic wl, input logic wh, input logic ce,
                     input logic [15:0] a, input logic [17:0] d,
                     input int kind, input int ea, input string req);
    exp_t it;
    @(posedge clk); #2;
    proc_start_n = ps; ctrl_start_n = cs; adv_n = adv;
    lo_we_n = wl; hi_we_n = wh; sel_n = ce; addr = a; din = d;
    if (kind == 2) begin
      if (sb.size() > 0) begin
        it = sb.pop_back();
        it.drive = 1'b0;
        sb.push_back(it);
      end
      if (!wl) shadow[ea % 256][8:0]  = d[8:0];
      if (!wh) shadow[ea % 256][17:9] = d[17:9];
    end
    it.due   = edges + 2;
    it.drive = (kind == 1);
    it.data  = (kind == 1) ? shadow[ea % 256] : 18'h0;
    it.req   = req;
    sb.push_back(it);
  endtask

  task automatic dsel();
    cyc(0, 1, 1, 1, 1, 1, 16'h0, 18'h0, 0, 0, "R9");
  endtask
  task automatic cwr(input int a, input logic [17:0] d, input logic wl, input logic wh, input string req);
    cyc(1, 0, 1, wl, wh, 0, 16'(a), d, 2, a, req);
  endtask
  task automatic prd(input int a, input string req);
    cyc(0, 1, 1, 1, 1, 0, 16'(a), 18'h0, 1, a, req);
  endtask
  task automatic crd(input int a, input string req);
    cyc(1, 0, 1, 1, 1, 0, 16'(a), 18'h0, 1, a, req);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    exp_t it;
    logic exp_en;
    if (sb.size() > 0 && sb[0].due == edges) begin
      it = sb.pop_front();
      exp_en = it.drive && !oe_n;
      checks++;
      if (dout_en !== exp_en) begin
        fails++;
        $display("FAIL %s: dout_en=%b expected %b", it.req, dout_en, exp_en);
      end else if (exp_en && dout !== it.data) begin
        fails++;
        $display("FAIL %s: dout=%h expected %h", it.req, dout, it.data);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (dout_en !== 1'b0) begin
      fails++;
      $display("FAIL R11: dout_en=%b in reset, expected 0", dout_en);
    end
    @(posedge clk); #2;
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (dout_en !== 1'b0) begin
      fails++;
      $display("FAIL R11: dout_en=%b after reset, expected 0", dout_en);
    end

    // fill with controller writes (R4), then single reads (R2)
    for (int i = 0; i < 96; i++) cwr(i, pat(i), 0, 0, "R4");
    prd(3, "R2"); crd(4, "R4"); prd(95, "R2");
    dsel();

    // single lane writes (R1)
    cwr(16'h10, 18'h3FFFF, 0, 1, "R1");
    cwr(16'h11, 18'h3FFFF, 1, 0, "R1");
    crd(16'h10, "R1"); crd(16'h11, "R1");
    dsel();

    // processor start with lane enables low is a read (R3)
    cyc(0, 1, 1, 0, 0, 0, 16'h12, 18'h15555, 1, 16'h12, "R3");
    dsel();
    prd(16'h12, "R3");
    dsel();

    // two-cycle processor write (R5), including one lane only
    prd(16'h20, "R5");
    cyc(1, 1, 1, 0, 0, 0, 16'h99, 18'h0ABCD, 2, 16'h20, "R5");
    dsel();
    prd(16'h21, "R5");
    cyc(1, 1, 1, 1, 0, 0, 16'h00, 18'h3E000, 2, 16'h21, "R5");
    dsel();
    crd(16'h20, "R5"); crd(16'h21, "R5");
    dsel();

    // read burst from mid-group with a suspend and wrap (R6, R7)
    prd(16'h32, "R6");
    cyc(1, 1, 0, 1, 1, 0, 16'h0, 18'h0, 1, beat_addr(16'h32, 1), "R6");
    cyc(1, 1, 1, 1, 1, 0, 16'h0, 18'h0, 1, beat_addr(16'h32, 1), "R7");
    cyc(1, 1, 0, 1, 1, 0, 16'h0, 18'h0, 1, beat_addr(16'h32, 2), "R6");
    cyc(1, 1, 0, 1, 1, 0, 16'h0, 18'h0, 1, beat_addr(16'h32, 3), "R6");
    cyc(1, 1, 0, 1, 1, 0, 16'h0, 18'h0, 1, 16'h32, "R6");
    dsel();

    // write burst started by controller (R4, R6), with a held write (R7)
    cwr(16'h41, 18'h11111, 0, 0, "R4");
    cyc(1, 1, 0, 0, 0, 0, 16'h0, 18'h22222, 2, beat_addr(16'h41, 1), "R6");
    cyc(1, 1, 1, 0, 1, 0, 16'h0, 18'h00077, 2, beat_addr(16'h41, 1), "R7");
    cyc(1, 1, 0, 0, 0, 0, 16'h0, 18'h33333, 2, beat_addr(16'h41, 2), "R6");
    cyc(1, 1, 0, 0, 0, 0, 16'h0, 18'h04444, 2, beat_addr(16'h41, 3), "R6");
    cyc(1, 1, 1, 1, 1, 0, 16'h0, 18'h0, 1, beat_addr(16'h41, 3), "R7");
    dsel();
    for (int i = 16'h40; i < 16'h44; i++) crd(i, "R6");
    dsel();

    // deselect closes the burst; later burst cycles do nothing (R9)
    prd(16'h50, "R9");
    dsel();
    cyc(1, 1, 0, 0, 0, 0, 16'h0, 18'h3AAAA, 0, 0, "R9");
    cyc(1, 1, 1, 0, 0, 0, 16'h0, 18'h3AAAA, 0, 0, "R9");
    cyc(1, 0, 1, 0, 0, 1, 16'h52, 18'h3BBBB, 0, 0, "R9");
    cyc(1, 1, 1, 1, 1, 0, 16'h0, 18'h0, 0, 0, "R9");
    for (int i = 16'h50; i < 16'h54; i++) prd(i, "R9");
    dsel();

    // output enable high keeps the bus released (R8)
    oe_n = 1'b1;
    prd(16'h05, "R8");
    dsel(); dsel(); dsel();
    oe_n = 1'b0;
    // read right before a controller write: read is not driven (R8)
    prd(16'h06, "R8");
    cwr(16'h07, 18'h12345, 0, 0, "R8");
    crd(16'h06, "R8");
    dsel();

    // upper address bits ignored (R10)
    cwr(16'hAB07, 18'h2468A, 0, 0, "R10");
    prd(16'h0007, "R10");
    prd(16'hFF07, "R10");
    dsel(); dsel(); dsel(); dsel();

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule